// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block gathers a parameterised set of level-sensitive peripheral interrupt lines, from two to five 32-bit words' worth, and drives one interrupt line per CPU. Every CPU owns a private bank of registers. Each bank holds a pending view, which is the inputs filtered by that CPU's mask, and a readable copy of the mask. It also has two write-only strobe registers. Writing ones to the first masks those bits, and writing ones to the second unmasks them. Software can therefore steer any source to any CPU, and adjust masks without a read-modify-write race.

There is no priority logic, no queue, no edge capture and no polarity control. An interrupt handler reads every pending word of its own bank to find the active sources. A pending bit stays high for as long as its input is high and the bit is unmasked. It drops when the source goes low or when software masks it.

The bus is a plain synchronous port. Address and write-enable are sampled on the rising clock edge. Read data is registered and appears one cycle after the address. The reset input is asynchronous and active low. Its release is synchronised inside the block over two clock edges.

Top module: `l1agg_top`

## Requirements
- R1: While reset is held and after it is released, every interrupt is masked for every CPU, all `cpu_irq` lines are low whatever `irq_in` does, and `bus_rdata` is zero.
- R2: The word address is split into three fields: `bus_addr[2:0]` is the status word index, `bus_addr[4:3]` is the register kind (0 pending, 1 mask view, 2 mask-set strobe, 3 mask-clear strobe), and `bus_addr[ADDR_W-1:5]` is the CPU index. Reading kind 0 returns `irq_in & ~mask` for that CPU and word, with bit i of word w standing for input 32*w+i. The value appears on `bus_rdata` one clock after the address is presented.
- R3: Reading kind 1 returns that CPU's mask bits for the word, where 1 means masked.
- R4: Writing kind 2 sets the mask bits where `bus_wdata` is 1. Mask bits where `bus_wdata` is 0 keep their value.
- R5: Writing kind 3 clears the mask bits where `bus_wdata` is 1. Mask bits where `bus_wdata` is 0 keep their value.
- R6: `cpu_irq[c]` is high one clock after any input is high and unmasked for CPU c. It goes low one clock after every such input deasserts or is masked. A mask change takes effect on `cpu_irq` on the second clock edge after the write.
- R7: A write to one CPU's bank leaves the masks of every other CPU, and therefore their pending views and outputs, unchanged.
- R8: Reads of the write-only kinds 2 and 3 return zero.
- R9: An access whose word index is at or above the number of words, or whose CPU index is at or above the number of CPUs, changes no mask, and a read of it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| irq_in | input | NUM_IRQ | Level-sensitive peripheral interrupt lines |
| bus_addr | input | ADDR_W | Register word address (CPU, kind, word fields) |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | NUM_CPU | Registered interrupt line per CPU |

## Verification
The assertions check four things on every cycle. A set strobe leaves its ones masked, and a clear strobe leaves its ones unmasked. A bank that is not written holds its mask. Each CPU line follows the OR of that CPU's unmasked inputs one clock later. Write-only and unmapped reads return zero. Other behaviours only the bench scenarios can show: the all-masked state after reset, the pending and mask views returned at specific addresses, and the isolation of one CPU's mask from a write to another. The bench also toggles a source cycle by cycle to show that the pending word and the output track a level input with the stated latency.

// File: rtl/l1agg_pkg.sv
package l1agg_pkg;

  localparam int DATA_W       = 32;
  localparam int WORD_FIELD_W = 3;
  localparam int KIND_LSB     = 3;
  localparam int CPU_LSB      = 5;

  typedef enum logic [1:0] {
    REG_PEND   = 2'd0,
    REG_MASKED = 2'd1,
    REG_MSET   = 2'd2,
    REG_MCLR   = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/l1agg_decode.sv
module l1agg_decode
  import l1agg_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int WORDS   = 2,
  parameter int CPU_W   = 1,
  parameter int ADDR_W  = CPU_LSB + CPU_W
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    we,
  output logic [NUM_CPU-1:0]      cpu_sel,
  output logic [WORD_FIELD_W-1:0] word_idx,
  output reg_kind_e               kind,
  output logic                    valid,
  output logic                    wr_set,
  output logic                    wr_clr
);

  logic [CPU_W-1:0] cpu_field;
  logic             word_ok;
  logic             cpu_ok;

  always_comb begin
    word_idx  = addr[WORD_FIELD_W-1:0];
    kind      = reg_kind_e'(addr[KIND_LSB +: 2]);
    cpu_field = addr[CPU_LSB +: CPU_W];
    word_ok   = ({29'd0, word_idx} < WORDS);
    cpu_ok    = ({{(32-CPU_W){1'b0}}, cpu_field} < NUM_CPU);
    valid     = word_ok && cpu_ok;
    wr_set    = valid && we && (kind == REG_MSET);
    wr_clr    = valid && we && (kind == REG_MCLR);
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_sel
    assign cpu_sel[c] = valid && (cpu_field == CPU_W'(c));
  end

  // R9
  sel_onehot_chk: assert final (!valid -> (cpu_sel == '0));

endmodule

// File: rtl/l1agg_cpu_bank.sv
module l1agg_cpu_bank
  import l1agg_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int WORDS   = NUM_IRQ / DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IRQ-1:0]      irq_in,
  input  logic                    sel,
  input  logic                    wr_set,
  input  logic                    wr_clr,
  input  logic [WORD_FIELD_W-1:0] word_idx,
  input  reg_kind_e               kind,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rd_word,
  output logic                    irq_out
);

  logic [NUM_IRQ-1:0] mask_q, mask_d;
  logic [NUM_IRQ-1:0] set_vec, clr_vec, pend;
  logic               mask_en;
  logic               irq_q, irq_d;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign set_vec[w*DATA_W +: DATA_W] =
      (sel && wr_set && (word_idx == WORD_FIELD_W'(w))) ? wdata : '0;
    assign clr_vec[w*DATA_W +: DATA_W] =
      (sel && wr_clr && (word_idx == WORD_FIELD_W'(w))) ? wdata : '0;
  end

  // next state: a set has priority over a clear of the same bit
  always_comb begin
    pend    = irq_in & ~mask_q;
    mask_en = sel && (wr_set || wr_clr);
    mask_d  = (mask_q & ~clr_vec) | set_vec;
    irq_d   = |pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_out = irq_q;

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (word_idx == WORD_FIELD_W'(w)) begin
        case (kind)
          REG_PEND:   rd_word = pend[w*DATA_W +: DATA_W];
          REG_MASKED: rd_word = mask_q[w*DATA_W +: DATA_W];
          default:    rd_word = '0;
        endcase
      end
    end
  end

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((mask_q & $past(set_vec)) == $past(set_vec)));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((mask_q & $past(clr_vec & ~set_vec)) == '0));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && (wr_set || wr_clr)) |=> (mask_q == $past(mask_q)));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_in & ~mask_q) != '0) |=> irq_out);

  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_in & ~mask_q) == '0) |=> !irq_out);

endmodule

// File: rtl/l1agg_top.sv
module l1agg_top
  import l1agg_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter int ADDR_W  = CPU_LSB + CPU_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IRQ-1:0]  irq_in,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_CPU-1:0]  cpu_irq
);

  localparam int WORDS = NUM_IRQ / DATA_W;

  logic [1:0]              rst_pipe;
  logic                    rst_core_n;
  logic [NUM_CPU-1:0]      cpu_sel;
  logic [WORD_FIELD_W-1:0] word_idx;
  reg_kind_e               kind;
  logic                    valid, wr_set, wr_clr;
  logic [DATA_W-1:0]       bank_rd [NUM_CPU];
  logic [DATA_W-1:0]       rdata_d, rdata_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  l1agg_decode #(
    .NUM_CPU (NUM_CPU),
    .WORDS   (WORDS),
    .CPU_W   (CPU_W),
    .ADDR_W  (ADDR_W)
  ) i_decode (
    .addr     (bus_addr),
    .we       (bus_we),
    .cpu_sel  (cpu_sel),
    .word_idx (word_idx),
    .kind     (kind),
    .valid    (valid),
    .wr_set   (wr_set),
    .wr_clr   (wr_clr)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    l1agg_cpu_bank #(
      .NUM_IRQ (NUM_IRQ),
      .WORDS   (WORDS)
    ) i_bank (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .irq_in   (irq_in),
      .sel      (cpu_sel[c]),
      .wr_set   (wr_set),
      .wr_clr   (wr_clr),
      .word_idx (word_idx),
      .kind     (kind),
      .wdata    (bus_wdata),
      .rd_word  (bank_rd[c]),
      .irq_out  (cpu_irq[c])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (cpu_sel[c]) rdata_d = rdata_d | bank_rd[c];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R8
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((kind == REG_MSET) || (kind == REG_MCLR)) |=> (bus_rdata == '0));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !valid |=> (bus_rdata == '0));

  // R7
  one_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(cpu_sel));

endmodule

// File: tb/test_l1agg_top.sv
module test_l1agg_top;

  localparam int NUM_IRQ = 64;
  localparam int NUM_CPU = 2;
  localparam int ADDR_W  = 6;

  typedef struct packed {
    logic              is_wr;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic [63:0]       irq;
    logic [31:0]       exp_rd;
    logic [1:0]        exp_irq;
    logic [3:0]        req;
  } vec_t;

  // address = {cpu, kind[1:0], word[2:0]}
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h08, 32'h0,        64'h0,                  32'hFFFFFFFF, 2'b00, 4'd3}, // R3 reset mask
    '{1'b0, 6'h00, 32'h0,        64'hF0,                 32'h0,        2'b00, 4'd2}, // R2 all masked
    '{1'b1, 6'h18, 32'hF0,       64'hF0,                 32'h0,        2'b01, 4'd5}, // R5 unmask c0
    '{1'b0, 6'h00, 32'h0,        64'hF0,                 32'hF0,       2'b01, 4'd2}, // R2 pending
    '{1'b0, 6'h20, 32'h0,        64'hF0,                 32'h0,        2'b01, 4'd7}, // R7 c1 untouched
    '{1'b0, 6'h08, 32'h0,        64'hF0,                 32'hFFFFFF0F, 2'b01, 4'd3}, // R3 mask view
    '{1'b1, 6'h39, 32'h80000000, 64'h80000000_00000000, 32'h0,        2'b10, 4'd7}, // R7 c1 word1
    '{1'b0, 6'h21, 32'h0,        64'h80000000_00000000, 32'h80000000, 2'b10, 4'd2}, // R2 word1
    '{1'b0, 6'h28, 32'h0,        64'h80000000_00000000, 32'hFFFFFFFF, 2'b10, 4'd7}, // R7 c1 w0 mask
    '{1'b1, 6'h10, 32'h10,       64'hF0,                 32'h0,        2'b01, 4'd4}, // R4 set bit4
    '{1'b0, 6'h08, 32'h0,        64'hF0,                 32'hFFFFFF1F, 2'b01, 4'd4}, // R4 zeros kept
    '{1'b0, 6'h10, 32'h0,        64'hF0,                 32'h0,        2'b01, 4'd8}, // R8 set reads 0
    '{1'b0, 6'h18, 32'h0,        64'hF0,                 32'h0,        2'b01, 4'd8}, // R8 clr reads 0
    '{1'b1, 6'h1A, 32'hFFFFFFFF, 64'hF0,                 32'h0,        2'b01, 4'd9}, // R9 word2 write
    '{1'b0, 6'h09, 32'h0,        64'hF0,                 32'hFFFFFFFF, 2'b01, 4'd9}, // R9 no effect
    '{1'b0, 6'h0A, 32'h0,        64'hF0,                 32'h0,        2'b01, 4'd9}, // R9 read 0
    '{1'b1, 6'h10, 32'hFFFFFFFF, 64'hF0,                 32'h0,        2'b00, 4'd6}, // R6 mask drops
    '{1'b0, 6'h21, 32'h0,        64'h0,                  32'h0,        2'b00, 4'd6}  // R6 source drops
  };

  logic               clk;
  logic               rst_n;
  logic [NUM_IRQ-1:0] irq_in;
  logic [ADDR_W-1:0]  bus_addr;
  logic               bus_we;
  logic [31:0]        bus_wdata;
  logic [31:0]        bus_rdata;
  logic [NUM_CPU-1:0] cpu_irq;

  int tests;
  int fails;

  l1agg_top #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) i_l1agg_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    tests = 0; fails = 0;
    irq_in = '1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 64'(cpu_irq), 64'h0);
    chk("R1 rdata in reset", 64'(bus_rdata), 64'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 irq after reset, inputs high", 64'(cpu_irq), 64'h0);
    chk("R1 rdata after reset", 64'(bus_rdata), 64'h0);
    irq_in = '0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_in = VECS[i].irq; bus_addr = VECS[i].addr;
      bus_wdata = VECS[i].wdata; bus_we = VECS[i].is_wr;
      @(negedge clk);
      bus_we = 1'b0;
      if (!VECS[i].is_wr) begin
        tests++;
        if (bus_rdata !== VECS[i].exp_rd) begin
          fails++;
          $display("FAIL R%0d vec %0d rdata actual=%h expected=%h",
                   VECS[i].req, i, bus_rdata, VECS[i].exp_rd);
        end
      end
      @(negedge clk);
      tests++;
      if (cpu_irq !== VECS[i].exp_irq) begin
        fails++;
        $display("FAIL R%0d vec %0d cpu_irq actual=%b expected=%b",
                 VECS[i].req, i, cpu_irq, VECS[i].exp_irq);
      end
    end

    // R6 / R2: level tracking of bit 5 on CPU 0
    irq_in = '0;
    bus_write(6'h18, 32'h20);
    bus_addr = 6'h00;
    for (int i = 0; i < 8; i++) begin
      logic lvl;
      lvl = ((8'b1011_0010 >> i) & 8'h1) != 0;
      @(negedge clk);
      irq_in[5] = lvl;
      @(negedge clk);
      chk("R6 level track cpu_irq", 64'(cpu_irq[0]), 64'(lvl));
      chk("R2 level track pending", 64'(bus_rdata[5]), 64'(lvl));
      chk("R7 level track other cpu", 64'(cpu_irq[1]), 64'h0);
    end

    // R1: reset mid-run restores the all-masked state
    irq_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 before reset", 64'(cpu_irq[0]), 64'h1);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset drops irq", 64'(cpu_irq), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(6'h08, rd);
    chk("R1 mask restored c0", 64'(rd), 64'hFFFFFFFF);
    bus_read(6'h29, rd);
    chk("R1 mask restored c1 w1", 64'(rd), 64'hFFFFFFFF);
    chk("R1 irq stays low", 64'(cpu_irq), 64'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule